// File: doc/BRIEF.md
# Ethernet Receive RMON Statistics Counter Bank

This block keeps a bank of receive statistics counters for an Ethernet MAC. When a frame ends, the receive path presents a one-cycle report on the report inputs. The report gives the frame length in bytes, counted from the first destination address byte through the last FCS byte, with preamble and start delimiter left out. It also carries an FCS-good flag, a flag that the frame held a whole number of bytes, a VLAN-tag flag and a two-bit cast code. In that same clock edge the block sorts the frame into RMON-style length bins and error classes. The frame-size limit is 1518 bytes for untagged frames and 1522 bytes for tagged ones.

Every counter wraps to zero when it passes its maximum, and in doing so it sets its own carry bit. A mask register chooses which carry bits drive the single overflow event output. A simple register port reads any counter and handles the carry and mask registers, and a global clear input empties the bank.

Top module: `eth_rx_stats`

## Requirements
- R1: Six length bins (index 0: exactly 64 bytes, 1: 65–127, 2: 128–255, 3: 256–511, 4: 512–1023, 5: 1024–1518) each count every reported frame whose length falls in their range, whatever its FCS, alignment, tag or cast.
- R2: Counter index 6 counts frames that are VLAN-tagged, have a good FCS and are 1519 to 1522 bytes long; untagged or bad-FCS frames of that length leave it unchanged.
- R3: Counter index 7 adds the reported length and counter index 8 adds one for every reported frame, good or bad.
- R4: Cast code 1 is multicast, 2 broadcast, 0 and 3 unicast. Counter index 9 (multicast) and index 10 (broadcast) count only good-FCS frames from 64 bytes to the size limit, and broadcast never counts as multicast.
- R5: A frame under 64 bytes counts as a fragment (index 11) when its FCS is bad, integral or not, and as undersize (index 12) when its FCS is good.
- R6: A frame above the size limit (1518, or 1522 when tagged) counts as oversize (index 13) with good FCS and as jabber (index 14) with bad FCS, non-integral ones included.
- R7: Counter index 15 counts frames from 64 bytes to the size limit that have a bad FCS and a non-integral byte count.
- R8: A counter that passes its maximum wraps to zero and sets the carry bit whose position equals its index.
- R9: Writing address 16 clears every carry bit written as 1 and leaves the rest. An overflow in the same cycle as the clear leaves its bit set.
- R10: The overflow output is high exactly when some carry bit is set whose mask bit, written at address 17, is also set.
- R11: The global clear zeroes all counters and carry bits, takes priority over a report in the same cycle, and keeps the mask.
- R12: A read strobe at address A shows the data one edge later: counters at 0–15, the carry bits at 16, the mask at 17, zero at any other address.
- R13: After reset all counters, carry bits and the mask are zero and the overflow output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rptValid | input | 1 | End-of-frame report strobe, one cycle per frame |
| rptLen | input | 16 | Frame length in bytes, DA through FCS |
| rptFcsOk | input | 1 | FCS check passed |
| rptIntegral | input | 1 | Frame held a whole number of bytes |
| rptVlan | input | 1 | Frame carried a VLAN tag |
| rptCast | input | 2 | 0 unicast, 1 multicast, 2 broadcast, 3 unicast |
| clearAll | input | 1 | Zero all counters and carry bits |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regAddr | input | 5 | Register address |
| regWrData | input | 16 | Write data for carry clear or mask |
| regRdData | output | CNT_W (32) | Read data, valid one edge after the strobe |
| ovfIrq | output | 1 | Masked counter overflow event |

## Verification
A report that is sampled at a clock edge has updated every counter it touches and any carry bit by the time that edge has passed. The overflow output follows the carry and mask registers with no extra stage, so it changes on the same edge that sets a carry or writes the mask. A read returns its value one edge after the strobe. The bench drives every input on the falling edge and samples at the next falling edge, after exactly one rising edge, so each result is read in the cycle it becomes due and never one cycle early.

// File: rtl/eth_rx_stats_pkg.sv
package eth_rx_stats_pkg;

  localparam int unsigned NUM_CNT   = 16;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned CNT_IDX_W = $clog2(NUM_CNT);
  localparam int unsigned NUM_BINS  = 6;

  localparam logic [LEN_W-1:0] MIN_LEN  = 16'd64;
  localparam logic [LEN_W-1:0] STD_MAX  = 16'd1518;
  localparam logic [LEN_W-1:0] VLAN_MAX = 16'd1522;

  // upper edge of each length bin; lower edge is the previous upper edge + 1
  localparam logic [LEN_W-1:0] BIN_HI [NUM_BINS] =
    '{16'd64, 16'd127, 16'd255, 16'd511, 16'd1023, 16'd1518};

  // counter indices (also carry bit positions and read addresses)
  localparam int unsigned IDX_VLAN_OK = NUM_BINS;
  localparam int unsigned IDX_BYTES   = 7;
  localparam int unsigned IDX_PKTS    = 8;
  localparam int unsigned IDX_MCAST   = 9;
  localparam int unsigned IDX_BCAST   = 10;
  localparam int unsigned IDX_FRAG    = 11;
  localparam int unsigned IDX_UNDER   = 12;
  localparam int unsigned IDX_OVER    = 13;
  localparam int unsigned IDX_JAB     = 14;
  localparam int unsigned IDX_ALIGN   = 15;

  localparam logic [ADDR_W-1:0] CARRY_ADDR = 5'd16;
  localparam logic [ADDR_W-1:0] MASK_ADDR  = 5'd17;

  typedef enum logic [1:0] {
    CAST_UNI   = 2'd0,
    CAST_MULTI = 2'd1,
    CAST_BROAD = 2'd2,
    CAST_RSVD  = 2'd3
  } castType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               clr;
    logic [NUM_CNT-1:0] inc;
    logic [LEN_W-1:0]   addBytes;
    logic [NUM_CNT-1:0] carryClr;
    logic               maskWe;
    logic [NUM_CNT-1:0] maskData;
    logic               rdEn;
    logic [ADDR_W-1:0]  rdAddr;
  } statStrobe_t;

endpackage

// File: rtl/eth_rx_stats_ctrl.sv
module eth_rx_stats_ctrl
  import eth_rx_stats_pkg::*;
(
  input  logic               rptValid,
  input  logic [LEN_W-1:0]   rptLen,
  input  logic               rptFcsOk,
  input  logic               rptIntegral,
  input  logic               rptVlan,
  input  logic [1:0]         rptCast,
  input  logic               clearAll,
  input  logic               regRd,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_CNT-1:0] regWrData,
  output statStrobe_t        strobe
);

  logic [NUM_BINS-1:0] binHit;
  logic [LEN_W-1:0]    maxLen;
  logic                isShort, isLong, inRange, goodFrm, badFrm, vlanBand;

  // length bins, built from the edge table
  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    if (b == 0) begin : g_first
      assign binHit[b] = (rptLen >= MIN_LEN) && (rptLen <= BIN_HI[0]);
    end else begin : g_rest
      assign binHit[b] = (rptLen > BIN_HI[b-1]) && (rptLen <= BIN_HI[b]);
    end
  end

  assign maxLen   = rptVlan ? VLAN_MAX : STD_MAX;
  assign isShort  = rptLen < MIN_LEN;
  assign isLong   = rptLen > maxLen;
  assign inRange  = !isShort && !isLong;
  assign goodFrm  = rptValid && rptFcsOk;
  assign badFrm   = rptValid && !rptFcsOk;
  assign vlanBand = (rptLen > STD_MAX) && (rptLen <= VLAN_MAX);

  always_comb begin
    strobe = '0;
    strobe.clr                   = clearAll;
    strobe.addBytes              = rptLen;
    strobe.inc[NUM_BINS-1:0]     = binHit & {NUM_BINS{rptValid}};
    strobe.inc[IDX_VLAN_OK]      = goodFrm && rptVlan && vlanBand;
    strobe.inc[IDX_BYTES]        = rptValid;
    strobe.inc[IDX_PKTS]         = rptValid;
    strobe.inc[IDX_MCAST]        = goodFrm && inRange && (rptCast == CAST_MULTI);
    strobe.inc[IDX_BCAST]        = goodFrm && inRange && (rptCast == CAST_BROAD);
    strobe.inc[IDX_FRAG]         = badFrm && isShort;
    strobe.inc[IDX_UNDER]        = goodFrm && isShort;
    strobe.inc[IDX_OVER]         = goodFrm && isLong;
    strobe.inc[IDX_JAB]          = badFrm && isLong;
    strobe.inc[IDX_ALIGN]        = badFrm && inRange && !rptIntegral;
    strobe.carryClr              = (regWr && regAddr == CARRY_ADDR) ? regWrData : '0;
    strobe.maskWe                = regWr && (regAddr == MASK_ADDR);
    strobe.maskData              = regWrData;
    strobe.rdEn                  = regRd;
    strobe.rdAddr                = regAddr;
  end

endmodule

// File: rtl/eth_rx_stats_dp.sv
module eth_rx_stats_dp
  import eth_rx_stats_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  statStrobe_t                    strobe,
  output logic [NUM_CNT-1:0][CNT_W-1:0]  cntArr,
  output logic [NUM_CNT-1:0]             carryVec,
  output logic [NUM_CNT-1:0]             maskVec,
  output logic [CNT_W-1:0]               rdData,
  output logic                           ovfIrq
);

  localparam int unsigned SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;

  logic [NUM_CNT-1:0] wrapHit;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [CNT_W-1:0] cntQ;
    logic [SUM_W-1:0] stepVal, sumVal;

    if (g == IDX_BYTES) begin : g_byteStep
      assign stepVal = SUM_W'(strobe.addBytes);
    end else begin : g_unitStep
      assign stepVal = SUM_W'(1);
    end

    assign sumVal     = SUM_W'(cntQ) + stepVal;
    assign wrapHit[g] = strobe.inc[g] && (sumVal[SUM_W-1:CNT_W] != '0);
    assign cntArr[g]  = cntQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cntQ <= '0;
      else if (strobe.clr)    cntQ <= '0;
      else if (strobe.inc[g]) cntQ <= sumVal[CNT_W-1:0];
    end
  end

  // carry bits: write-one-to-clear, a new overflow wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           carryVec <= '0;
    else if (strobe.clr) carryVec <= '0;
    else                 carryVec <= (carryVec & ~strobe.carryClr) | wrapHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskVec <= '0;
    else if (strobe.maskWe) maskVec <= strobe.maskData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdEn) begin
      if (strobe.rdAddr < ADDR_W'(NUM_CNT))
        rdData <= cntArr[strobe.rdAddr[CNT_IDX_W-1:0]];
      else if (strobe.rdAddr == CARRY_ADDR)
        rdData <= CNT_W'(carryVec);
      else if (strobe.rdAddr == MASK_ADDR)
        rdData <= CNT_W'(maskVec);
      else
        rdData <= '0;
    end
  end

  assign ovfIrq = |(carryVec & maskVec);

endmodule

// File: rtl/eth_rx_stats.sv
module eth_rx_stats
  import eth_rx_stats_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rptValid,
  input  logic [LEN_W-1:0]   rptLen,
  input  logic               rptFcsOk,
  input  logic               rptIntegral,
  input  logic               rptVlan,
  input  logic [1:0]         rptCast,
  input  logic               clearAll,
  input  logic               regRd,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_CNT-1:0] regWrData,
  output logic [CNT_W-1:0]   regRdData,
  output logic               ovfIrq
);

  statStrobe_t                   strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntArr;
  logic [NUM_CNT-1:0]            carryVec;
  logic [NUM_CNT-1:0]            maskVec;

  eth_rx_stats_ctrl u_ctrl (
    .rptValid    (rptValid),
    .rptLen      (rptLen),
    .rptFcsOk    (rptFcsOk),
    .rptIntegral (rptIntegral),
    .rptVlan     (rptVlan),
    .rptCast     (rptCast),
    .clearAll    (clearAll),
    .regRd       (regRd),
    .regWr       (regWr),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .strobe      (strobe)
  );

  eth_rx_stats_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cntArr   (cntArr),
    .carryVec (carryVec),
    .maskVec  (maskVec),
    .rdData   (regRdData),
    .ovfIrq   (ovfIrq)
  );

endmodule

// File: rtl/eth_rx_stats_chk.sv
module eth_rx_stats_chk
  import eth_rx_stats_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          rptValid,
  input logic                          rptVlan,
  input logic                          rptFcsOk,
  input logic                          clearAll,
  input logic                          regRd,
  input logic [ADDR_W-1:0]             regAddr,
  input logic [CNT_W-1:0]              regRdData,
  input logic                          ovfIrq,
  input logic [NUM_CNT-1:0]            incVec,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntArr,
  input logic [NUM_CNT-1:0]            carryVec
);

  assert_bins_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(incVec[NUM_BINS-1:0]));

  assert_vlan_bin_R2: assert property (@(posedge clk) disable iff (!rstN)
    incVec[IDX_VLAN_OK] |-> (rptValid && rptVlan && rptFcsOk));

  assert_pkt_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rptValid && !clearAll) |=> cntArr[IDX_PKTS] == CNT_W'($past(cntArr[IDX_PKTS]) + 1));

  assert_cast_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(incVec[IDX_MCAST] && incVec[IDX_BCAST]));

  assert_err_class_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(incVec[IDX_JAB:IDX_FRAG]));

  assert_carry_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((carryVec & ~$past(carryVec)) != '0) |-> $past(rptValid));

  assert_irq_needs_carry_R10: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> (carryVec != '0));

  assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (cntArr == '0) && (carryVec == '0) && !ovfIrq);

  assert_bad_addr_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr > MASK_ADDR) |=> regRdData == '0);

endmodule

bind eth_rx_stats eth_rx_stats_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rptValid  (rptValid),
  .rptVlan   (rptVlan),
  .rptFcsOk  (rptFcsOk),
  .clearAll  (clearAll),
  .regRd     (regRd),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .ovfIrq    (ovfIrq),
  .incVec    (strobe.inc),
  .cntArr    (cntArr),
  .carryVec  (carryVec)
);

// File: tb/sim_eth_rx_stats.sv
module sim_eth_rx_stats;

  localparam int CW = 16;
  localparam int NV = 24;

  // {len, fcsOk, integral, vlan, cast, expected increments excl. bytes/packets}
  localparam logic [36:0] VEC [NV] = '{
    {16'd64,   1'b1, 1'b1, 1'b0, 2'd0, 16'h0001},
    {16'd64,   1'b1, 1'b1, 1'b0, 2'd1, 16'h0201},
    {16'd63,   1'b1, 1'b1, 1'b0, 2'd2, 16'h1000},
    {16'd63,   1'b0, 1'b0, 1'b0, 2'd0, 16'h0800},
    {16'd65,   1'b1, 1'b1, 1'b0, 2'd2, 16'h0402},
    {16'd127,  1'b0, 1'b0, 1'b0, 2'd1, 16'h8002},
    {16'd128,  1'b0, 1'b1, 1'b0, 2'd0, 16'h0004},
    {16'd255,  1'b1, 1'b1, 1'b1, 2'd1, 16'h0204},
    {16'd256,  1'b1, 1'b1, 1'b0, 2'd3, 16'h0008},
    {16'd511,  1'b1, 1'b1, 1'b0, 2'd2, 16'h0408},
    {16'd512,  1'b1, 1'b1, 1'b0, 2'd0, 16'h0010},
    {16'd1023, 1'b0, 1'b0, 1'b0, 2'd0, 16'h8010},
    {16'd1024, 1'b1, 1'b1, 1'b0, 2'd1, 16'h0220},
    {16'd1518, 1'b1, 1'b1, 1'b0, 2'd2, 16'h0420},
    {16'd1519, 1'b1, 1'b1, 1'b0, 2'd1, 16'h2000},
    {16'd1519, 1'b1, 1'b1, 1'b1, 2'd1, 16'h0240},
    {16'd1522, 1'b1, 1'b1, 1'b1, 2'd0, 16'h0040},
    {16'd1523, 1'b1, 1'b1, 1'b1, 2'd0, 16'h2000},
    {16'd1522, 1'b0, 1'b0, 1'b1, 2'd0, 16'h8000},
    {16'd1519, 1'b0, 1'b0, 1'b0, 2'd0, 16'h4000},
    {16'd1600, 1'b0, 1'b1, 1'b1, 2'd2, 16'h4000},
    {16'd20,   1'b0, 1'b1, 1'b0, 2'd0, 16'h0800},
    {16'd1520, 1'b0, 1'b1, 1'b1, 2'd0, 16'h0000},
    {16'd64,   1'b0, 1'b0, 1'b0, 2'd2, 16'h8001}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rptValid = 1'b0, rptFcsOk = 1'b0, rptIntegral = 1'b0, rptVlan = 1'b0;
  logic [15:0]   rptLen = '0;
  logic [1:0]    rptCast = '0;
  logic          clearAll = 1'b0, regRd = 1'b0, regWr = 1'b0;
  logic [4:0]    regAddr = '0;
  logic [15:0]   regWrData = '0;
  logic [CW-1:0] regRdData;
  logic          ovfIrq;

  int nChecks = 0;
  int nErr    = 0;

  logic [CW-1:0] mCnt [16];
  logic [15:0]   mCarry;
  logic [CW-1:0] rdVal;

  always #4 clk = ~clk;

  eth_rx_stats #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .rptValid(rptValid), .rptLen(rptLen),
    .rptFcsOk(rptFcsOk), .rptIntegral(rptIntegral), .rptVlan(rptVlan),
    .rptCast(rptCast), .clearAll(clearAll), .regRd(regRd), .regWr(regWr),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .ovfIrq(ovfIrq)
  );

  function automatic string tagOf(input int idx);
    if (idx < 6)  return "R1";
    if (idx == 6) return "R2";
    if (idx < 9)  return "R3";
    if (idx < 11) return "R4";
    if (idx < 13) return "R5";
    if (idx < 15) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; model follows the requirements
  task automatic drive(input bit rv, input logic [15:0] len, input bit fcs, input bit integ,
                       input bit vlan, input logic [1:0] ct, input logic [15:0] inc,
                       input bit wv, input logic [4:0] wa, input logic [15:0] wd,
                       input bit clr);
    logic [16:0] sum;
    @(negedge clk);
    rptValid = rv; rptLen = len; rptFcsOk = fcs; rptIntegral = integ;
    rptVlan = vlan; rptCast = ct; regWr = wv; regAddr = wa; regWrData = wd;
    clearAll = clr;
    @(negedge clk);
    rptValid = 1'b0; regWr = 1'b0; clearAll = 1'b0;
    if (clr) begin
      for (int i = 0; i < 16; i++) mCnt[i] = '0;
      mCarry = '0;
    end else begin
      if (wv && wa == 5'd16) mCarry = mCarry & ~wd;
      if (rv) begin
        for (int i = 0; i < 16; i++) begin
          if ((inc | 16'h0180) & (16'h1 << i)) begin
            sum = {1'b0, mCnt[i]} + ((i == 7) ? {1'b0, len} : 17'd1);
            if (sum[16]) mCarry[i] = 1'b1;
            mCnt[i] = sum[15:0];
          end
        end
      end
    end
  endtask

  task automatic sendFrame(input logic [15:0] len, input bit fcs, input bit integ,
                           input bit vlan, input logic [1:0] ct, input logic [15:0] inc);
    drive(1'b1, len, fcs, integ, vlan, ct, inc, 1'b0, 5'd0, 16'h0, 1'b0);
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [15:0] d);
    drive(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b1, a, d, 1'b0);
  endtask

  task automatic readReg(input logic [4:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdData;
  endtask

  task automatic checkCounters(input string ctx);
    logic [CW-1:0] d;
    for (int i = 0; i < 16; i++) begin
      readReg(5'(i), d);
      chk($sformatf("%s/%s idx%0d", ctx, tagOf(i), i), 32'(d), 32'(mCnt[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mCnt[i] = '0;
    mCarry = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R13: reset state
    chk("R13 irq", 32'(ovfIrq), 32'd0);
    readReg(5'd8, rdVal);  chk("R13 packets", 32'(rdVal), 32'd0);
    readReg(5'd16, rdVal); chk("R13 carry", 32'(rdVal), 32'd0);
    readReg(5'd17, rdVal); chk("R13 mask", 32'(rdVal), 32'd0);

    // vector table: R1..R7 classification
    for (int v = 0; v < NV; v++)
      sendFrame(VEC[v][36:21], VEC[v][20], VEC[v][19], VEC[v][18], VEC[v][17:16], VEC[v][15:0]);
    checkCounters("table");
    readReg(5'd16, rdVal); chk("R8 no carry yet", 32'(rdVal), 32'(mCarry));

    // R12: read of counter then unmapped address
    readReg(5'd8, rdVal);  chk("R12 read packets", 32'(rdVal), 32'(mCnt[8]));
    readReg(5'd21, rdVal); chk("R12 unmapped", 32'(rdVal), 32'd0);

    // R8: byte counter wraps and sets carry bit 7
    while (int'(mCnt[7]) + 1500 < 65536)
      sendFrame(16'd1500, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0020);
    sendFrame(16'd1500, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0020);
    readReg(5'd7, rdVal);  chk("R8 wrapped bytes", 32'(rdVal), 32'(mCnt[7]));
    readReg(5'd16, rdVal); chk("R8 carry bit7", 32'(rdVal), 32'h0080);
    chk("R10 masked off", 32'(ovfIrq), 32'd0);

    // R9 / R10: write-one-to-clear and masking
    writeReg(5'd16, 16'h0000);
    readReg(5'd16, rdVal); chk("R9 zero write keeps", 32'(rdVal), 32'h0080);
    writeReg(5'd17, 16'h0001);
    chk("R10 other bit masked", 32'(ovfIrq), 32'd0);
    writeReg(5'd17, 16'h0080);
    chk("R10 irq raised", 32'(ovfIrq), 32'd1);
    readReg(5'd17, rdVal); chk("R12 mask read", 32'(rdVal), 32'h0080);
    writeReg(5'd16, 16'h0080);
    readReg(5'd16, rdVal); chk("R9 cleared", 32'(rdVal), 32'h0000);
    chk("R10 irq dropped", 32'(ovfIrq), 32'd0);

    // R9: overflow in the same cycle as the clear keeps the bit
    while (int'(mCnt[7]) + 1500 < 65536)
      sendFrame(16'd1500, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0020);
    drive(1'b1, 16'd1500, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0020, 1'b1, 5'd16, 16'h0080, 1'b0);
    readReg(5'd16, rdVal); chk("R9 set wins", 32'(rdVal), 32'h0080);
    chk("R10 irq on set-wins", 32'(ovfIrq), 32'd1);

    // R11: global clear beats a report in the same cycle, mask kept
    drive(1'b1, 16'd64, 1'b1, 1'b1, 1'b0, 2'd1, 16'h0201, 1'b0, 5'd0, 16'h0, 1'b1);
    chk("R11 irq", 32'(ovfIrq), 32'd0);
    checkCounters("R11 cleared");
    readReg(5'd16, rdVal); chk("R11 carry", 32'(rdVal), 32'd0);
    readReg(5'd17, rdVal); chk("R11 mask kept", 32'(rdVal), 32'h0080);

    // R1: counting resumes from zero
    sendFrame(16'd64, 1'b1, 1'b1, 1'b0, 2'd1, 16'h0201);
    readReg(5'd0, rdVal); chk("R1 after clear", 32'(rdVal), 32'd1);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule